// File: doc/BRIEF.md
# Phase-Offset Sine Oscillator Core

This block is a numerically controlled oscillator. A 32-bit phase accumulator grows by a programmable step on every clock. The top ten phase bits, shifted by a coarse 5-bit phase offset, address a quarter-wave sine table that is folded and sign-extended into a full period. The result is a 10-bit offset-binary sample for a DAC and a one-bit square wave that follows the sign of the sine.

A load strobe takes the step, the offset and a power-down flag from the input pins into the block. The step and the offset then travel through separate fixed delay lines. A step change and an offset change therefore reach the sample output after different, exactly known latencies. While power-down is in force, the accumulator holds its phase and the output rests at mid-scale.

Top module: `nco_sine_core`

## Requirements
- R1: While `rst_i` is high, `sample_o` is 512 and `square_o` is 0, and the loaded words and the accumulator are cleared. No later than 13 cycles after release, with no load, `sample_o` shows the phase-zero value 514.
- R2: `tune_i`, `pofs_i` and `pdn_i` are taken in only at clock edges where `load_i` is high. Changing them while `load_i` is low leaves the output unchanged.
- R3: The 32-bit accumulator adds the loaded step on every clock, modulo 2^32, so the output frequency is step * fclk / 2^32. Bits 31:22 of the accumulator form the 10-bit phase p that selects each sample.
- R4: A step loaded at edge k first affects `sample_o` at edge k+18. The sample at edge k+17 still follows the old step.
- R5: The 5-bit offset P is added to accumulator bits 31:27, which gives p = acc[31:22] + 32*P modulo 1024. Each offset unit is 11.25 degrees.
- R6: An offset loaded at edge k first appears in `sample_o` at edge k+13.
- R7: The sample is built from p as follows.
  - Let i = p[7:0], replaced by 255-i when p[8] is 1.
  - Let m = round(511*sin((2i+1)*pi/1024)).
  - `sample_o` is 512+m when p[9] is 0, and 511-m when p[9] is 1.
- R8: `square_o` is 1 exactly when p[9] is 0, in the same cycle as the sample for that p.
- R9: Power-down behaves as follows.
  - Loading `pdn_i`=1 at edge k forces `sample_o` to 512 and `square_o` to 0 from edge k+1, and the accumulator holds its value.
  - Loading `pdn_i`=0 at edge r gives the held phase at edges r+1 to r+3 and one more step at edge r+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high master reset |
| load_i | input | 1 | Load strobe for step, offset and power-down |
| tune_i | input | 32 | Frequency step (tuning word) |
| pofs_i | input | 5 | Phase offset in 11.25-degree units |
| pdn_i | input | 1 | Power-down request |
| sample_o | output | 10 | Offset-binary sine sample |
| square_o | output | 1 | Sign of the sine as a square wave |

## Verification
The bench builds the core with its default parameters: a 32-bit accumulator, a 10-bit phase into a 256-entry quarter table, 10-bit samples and latencies of 18 and 13. With these values, sweeping all 32 offsets at zero step lands on every quadrant boundary and every mirror case of the fold. A step of 0x12345678 wraps the accumulator within the observed run. The two latencies can be told apart because the first sample after a change differs clearly from the one before it.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // sine by odd power series, good to far below one LSB on [0, pi/2]
  function automatic real series_sin(input real x);
    real term;
    real sum;
    term = x;
    sum  = x;
    for (int n = 1; n < 12; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // magnitude of one quarter-wave table entry, sampled at bin centres
  function automatic int qsin_entry(input int idx, input int qn, input int amp);
    real ang;
    real v;
    ang = (2.0 * idx + 1.0) * 3.14159265358979323846 / (4.0 * qn);
    v   = amp * series_sin(ang) + 0.5;
    return $rtoi(v);
  endfunction

endpackage

// File: rtl/nco_delay.sv
module nco_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stage_q [DEPTH];
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q_o = stage_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             hold_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] acc_q;

  function automatic logic [ACC_W-1:0] advance(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] s);
    return a + s;  // wraps modulo 2^ACC_W
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i)        acc_q <= '0;
    else if (!hold_i) acc_q <= advance(acc_q, step_i);
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut
  import nco_pkg::*;
#(
  parameter int PH_W   = 10,
  parameter int SAMP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [PH_W-1:0]   ph_i,
  input  logic              force_mid_i,
  output logic [SAMP_W-1:0] sample_o,
  output logic              square_o
);

  localparam int QA    = PH_W - 2;
  localparam int QN    = 1 << QA;
  localparam int MAG_W = SAMP_W - 1;
  localparam int AMP   = (1 << (SAMP_W - 1)) - 1;
  localparam int MID   = 1 << (SAMP_W - 1);

  logic [MAG_W-1:0] qtab [QN];

  generate
    for (genvar g = 0; g < QN; g++) begin : g_tab
      localparam logic [MAG_W-1:0] ENTRY = MAG_W'(qsin_entry(g, QN, AMP));
      assign qtab[g] = ENTRY;
    end
  endgenerate

  function automatic logic [QA-1:0] fold_index(input logic [PH_W-1:0] ph);
    return ph[PH_W-2] ? ~ph[QA-1:0] : ph[QA-1:0];
  endfunction

  function automatic logic [SAMP_W-1:0] to_sample(input logic neg,
                                                  input logic [MAG_W-1:0] mag);
    return neg ? SAMP_W'(MID - 1) - {1'b0, mag}
               : SAMP_W'(MID) + {1'b0, mag};
  endfunction

  logic [MAG_W-1:0]  mag_q;
  logic              neg_q;
  logic [SAMP_W-1:0] sample_q;
  logic              square_q;

  // stage 1: fold and table read
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else begin
      mag_q <= qtab[fold_index(ph_i)];
      neg_q <= ph_i[PH_W-1];
    end
  end

  // stage 2: sign, offset binary, power-down force
  always_ff @(posedge clk_i) begin
    if (rst_i || force_mid_i) begin
      sample_q <= SAMP_W'(MID);
      square_q <= 1'b0;
    end else begin
      sample_q <= to_sample(neg_q, mag_q);
      square_q <= ~neg_q;
    end
  end

  assign sample_o = sample_q;
  assign square_o = square_q;

endmodule

// File: rtl/nco_sine_core.sv
module nco_sine_core
  import nco_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int OFS_W     = 5,
  parameter int PH_W      = 10,
  parameter int SAMP_W    = 10,
  parameter int FREQ_LAT  = 18,
  parameter int PHASE_LAT = 13
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [ACC_W-1:0]  tune_i,
  input  logic [OFS_W-1:0]  pofs_i,
  input  logic              pdn_i,
  output logic [SAMP_W-1:0] sample_o,
  output logic              square_o
);

  // registers after the delay lines: accumulator, phase, table, output
  localparam int F_DLY = FREQ_LAT - 4;
  // registers after the delay line: phase, table, output
  localparam int P_DLY = PHASE_LAT - 3;

  logic [ACC_W-1:0] tune_act;
  logic [OFS_W-1:0] pofs_act;
  logic             pd_act;
  logic [ACC_W-1:0] tune_eff;
  logic [OFS_W-1:0] pofs_eff;
  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  ph_q;

  function automatic logic [PH_W-1:0] phase_index(input logic [ACC_W-1:0] acc,
                                                  input logic [OFS_W-1:0] ofs);
    logic [PH_W-1:0] ofs_ext;
    ofs_ext = PH_W'(ofs) << (PH_W - OFS_W);
    return acc[ACC_W-1 -: PH_W] + ofs_ext;
  endfunction

  // load interface capture
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tune_act <= '0;
      pofs_act <= '0;
      pd_act   <= 1'b0;
    end else if (load_i) begin
      tune_act <= tune_i;
      pofs_act <= pofs_i;
      pd_act   <= pdn_i;
    end
  end

  nco_delay #(.W(ACC_W), .DEPTH(F_DLY)) u_fdly (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(tune_act), .q_o(tune_eff)
  );

  nco_delay #(.W(OFS_W), .DEPTH(P_DLY)) u_pdly (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(pofs_act), .q_o(pofs_eff)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_i(rst_i), .hold_i(pd_act),
    .step_i(tune_eff), .acc_o(acc_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) ph_q <= '0;
    else       ph_q <= phase_index(acc_q, pofs_eff);
  end

  nco_sine_lut #(.PH_W(PH_W), .SAMP_W(SAMP_W)) u_lut (
    .clk_i(clk_i), .rst_i(rst_i), .ph_i(ph_q), .force_mid_i(pd_act),
    .sample_o(sample_o), .square_o(square_o)
  );

endmodule

// File: rtl/nco_sine_core_chk.sv
module nco_sine_core_chk #(
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 5,
  parameter int SAMP_W = 10
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              load_i,
  input logic              pd_act,
  input logic [ACC_W-1:0]  acc_q,
  input logic [ACC_W-1:0]  tune_act,
  input logic [OFS_W-1:0]  pofs_act,
  input logic [SAMP_W-1:0] sample_o,
  input logic              square_o
);

  localparam int MID = 1 << (SAMP_W - 1);

  // R1
  reset_mid_chk: assert property (@(posedge clk_i)
    rst_i |=> (sample_o == SAMP_W'(MID)) && !square_o);

  // R2
  no_load_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> $stable(tune_act) && $stable(pofs_act));

  // R9
  pdown_mid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pd_act |=> (sample_o == SAMP_W'(MID)) && !square_o);

  // R9
  pdown_acc_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pd_act |=> $stable(acc_q));

  // R8
  square_pos_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    square_o |-> sample_o[SAMP_W-1]);

  // R8
  square_neg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!square_o && sample_o != SAMP_W'(MID)) |-> !sample_o[SAMP_W-1]);

endmodule

bind nco_sine_core nco_sine_core_chk #(
  .ACC_W(ACC_W), .OFS_W(OFS_W), .SAMP_W(SAMP_W)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i), .pd_act(pd_act),
  .acc_q(acc_q), .tune_act(tune_act), .pofs_act(pofs_act),
  .sample_o(sample_o), .square_o(square_o)
);

// File: tb/test_nco_sine_core.sv
`timescale 1ns/1ps
module test_nco_sine_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [31:0] tune = '0;
  logic [4:0]  pofs = '0;
  logic        pdn = 1'b0;
  logic [9:0]  sample;
  logic        square;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nco_sine_core i_nco_sine_core (
    .clk_i(clk), .rst_i(rst), .load_i(load), .tune_i(tune),
    .pofs_i(pofs), .pdn_i(pdn), .sample_o(sample), .square_o(square)
  );

  // expected sample for a 10-bit phase, straight from the R7 formula
  function automatic logic [9:0] exp_sample(input int unsigned p);
    int unsigned q;
    int unsigned i;
    real m;
    int mag;
    q = (p >> 8) & 3;
    i = p & 255;
    if ((q & 1) != 0) i = 255 - i;
    m = 511.0 * $sin((2.0 * i + 1.0) * 3.141592653589793 / 1024.0);
    mag = $rtoi(m + 0.5);
    if ((q & 2) != 0) return 10'(511 - mag);
    return 10'(512 + mag);
  endfunction

  function automatic logic exp_square(input int unsigned p);
    return ((p >> 9) & 1) == 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_load(input logic [31:0] t, input logic [4:0] p, input logic d);
    @(negedge clk);
    tune = t; pofs = p; pdn = d; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; load = 1'b0; tune = '0; pofs = '0; pdn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset sample", 32'(sample), 32'd512);
    check("R1 reset square", 32'(square), 32'd0);
    rst = 1'b0;
    repeat (13) @(negedge clk);
    check("R1 settled phase-zero sample", 32'(sample), 32'd514);
  endtask

  task automatic t_phase_sweep();
    int unsigned prev;
    do_reset();
    prev = 0;
    for (int pv = 0; pv < 32; pv++) begin
      pulse_load(32'd0, 5'(pv), 1'b0);
      repeat (12) @(negedge clk);
      check("R6 offset not yet visible at k+12", 32'(sample), 32'(exp_sample(prev * 32)));
      @(negedge clk);
      check("R5 R7 offset sample at k+13", 32'(sample), 32'(exp_sample(pv * 32)));
      check("R8 offset square", 32'(square), 32'(exp_square(pv * 32)));
      prev = pv;
    end
  endtask

  task automatic t_ignore();
    // continues from the sweep: offset 31, step 0
    @(negedge clk);
    tune = 32'hFFFF_0000; pofs = 5'd3; pdn = 1'b1;
    repeat (25) @(negedge clk);
    check("R2 inputs without load ignored", 32'(sample), 32'(exp_sample(31 * 32)));
    check("R2 square unchanged", 32'(square), 32'(exp_square(31 * 32)));
    tune = '0; pofs = '0; pdn = 1'b0;
  endtask

  task automatic t_freq();
    logic [31:0] st;
    logic [31:0] a;
    st = 32'h1234_5678;
    do_reset();
    pulse_load(st, 5'd0, 1'b0);
    repeat (17) @(negedge clk);
    check("R4 step not yet visible at k+17", 32'(sample), 32'd514);
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      a = st * 32'(j + 1);
      check("R3 R4 stepped sample", 32'(sample), 32'(exp_sample(a[31:22])));
      check("R8 stepped square", 32'(square), 32'(exp_square(a[31:22])));
    end
  endtask

  task automatic t_pdown();
    logic [31:0] st;
    logic [31:0] a;
    st = 32'h1234_5678;
    do_reset();
    pulse_load(st, 5'd0, 1'b0);          // edge k0
    repeat (18) @(negedge clk);
    pulse_load(st, 5'd0, 1'b1);          // edge k0+20, accumulator = 6*step
    @(negedge clk);
    check("R9 forced mid-scale", 32'(sample), 32'd512);
    check("R9 forced square low", 32'(square), 32'd0);
    repeat (8) @(negedge clk);
    check("R9 still mid-scale", 32'(sample), 32'd512);
    pulse_load(st, 5'd0, 1'b0);          // edge r
    check("R9 mid-scale at release edge", 32'(sample), 32'd512);
    a = st * 32'd6;
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      check("R9 held phase after release", 32'(sample), 32'(exp_sample(a[31:22])));
    end
    @(negedge clk);
    a = st * 32'd7;
    check("R9 one step after release", 32'(sample), 32'(exp_sample(a[31:22])));
    @(negedge clk);
    a = st * 32'd8;
    check("R9 second step after release", 32'(sample), 32'(exp_sample(a[31:22])));
  endtask

  initial begin
    t_reset();
    t_phase_sweep();
    t_ignore();
    t_freq();
    t_pdown();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule